// File: doc/BRIEF.md
# Loop Capture Detector

This block watches each instruction leaving the decode stage and decides whether a control-transfer instruction closes a loop small enough to be held entirely in the issue queue. A loop is a candidate when the instruction is a conditional branch or a direct jump, and its predicted target lies below its own address. The body, counted in 32-bit instruction words from the target up to and including the branch, must also fit in the configured queue capacity. The check uses the predicted target, so it can act before the branch resolves.

When a candidate passes, the block raises a one-cycle buffering request that carries the loop start (the target) and the loop end (the branch address). The queue controller uses this request to start capturing at the top of the following iteration, not the one already in flight. The block keeps a small table of loops whose earlier capture attempts failed. The controller reports each failed attempt with a cause code. For the causes that mark a loop as unfit, the branch address is recorded, and later decodes of that branch raise no request. While the controller reports any state other than normal, no request is raised.

Top module: `loop_capture_detector`

## Requirements
- R1: Only instruction kind 2'b01 (conditional branch) and 2'b10 (direct jump) can produce a request. Kinds 2'b00 (other) and 2'b11 (call) never do.
- R2: The predicted target must be strictly lower than the instruction address. A forward target or a target equal to the address produces no request.
- R3: The body size (address - target)/4 + 1 must be less than or equal to the capacity input. A size equal to the capacity qualifies, and a size one larger does not.
- R4: A qualifying decode with decode-valid high makes `req_valid_o` high for exactly the cycle after it, with `req_start_pc_o` equal to the target and `req_end_pc_o` equal to the instruction address. Back-to-back qualifying decodes give back-to-back requests. The same fields with decode-valid low give no request.
- R5: No request is raised for a decode presented while `ctl_normal_i` is low.
- R6: No request is raised for a decode whose address matches a valid entry in the non-bufferable table.
- R7: An abort report with cause 2'b01 (inner loop seen), 2'b10 (execution left the loop) or 2'b11 (call filled the queue) writes its tag into the table. Cause 2'b00 (other revoke) writes nothing.
- R8: The table holds NBL_DEPTH entries (default 8) and replaces them round-robin. After NBL_DEPTH+1 distinct insertions following reset, the first tag has been evicted and the second is still present.
- R9: An abort that records a tag in the same cycle as a decode of that same address suppresses the request for that decode.
- R10: After reset, no request is pending and the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dec_valid_i | input | 1 | A decoded instruction is presented |
| dec_pc_i | input | ADDR_W | Address of the decoded instruction |
| dec_kind_i | input | 2 | Instruction kind: 00 other, 01 conditional branch, 10 direct jump, 11 call |
| dec_target_i | input | ADDR_W | Predicted target address |
| iq_cap_i | input | CAP_W | Configured issue-queue capacity in entries |
| ctl_normal_i | input | 1 | Queue controller is in its normal state |
| abort_valid_i | input | 1 | Controller reports a failed capture attempt |
| abort_cause_i | input | 2 | Failure cause: 00 other, 01 inner loop, 10 loop left, 11 call overflow |
| abort_tag_i | input | ADDR_W | Branch address of the failed loop |
| req_valid_o | output | 1 | Start-buffering request, one cycle per qualifying decode |
| req_start_pc_o | output | ADDR_W | First address of the loop body |
| req_end_pc_o | output | ADDR_W | Address of the loop-closing instruction |

## Verification
The kind field is tested with all four codes on an otherwise qualifying loop, which separates the eligible kinds from calls and plain instructions. The target is placed below, above and exactly at the instruction address to test the strict backward rule. The capacity is set at the body size and one below it to find the boundary of the fit test. Abort reports with each cause code, a same-cycle abort and decode, and nine distinct insertions separate the recording, bypass and round-robin eviction behaviour from simple gating by the controller state.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  typedef enum logic [1:0] {
    KIND_OTHER = 2'b00,
    KIND_COND  = 2'b01,
    KIND_JUMP  = 2'b10,
    KIND_CALL  = 2'b11
  } ctl_kind_e;

  typedef enum logic [1:0] {
    ABT_OTHER     = 2'b00,
    ABT_INNER     = 2'b01,
    ABT_EXIT      = 2'b10,
    ABT_CALL_FULL = 2'b11
  } abort_cause_e;

  function automatic logic cause_marks_bad(logic [1:0] cause);
    return cause != ABT_OTHER;
  endfunction
endpackage

// File: rtl/lcd_qualify.sv
module lcd_qualify #(
  parameter int ADDR_W = 32,
  parameter int CAP_W  = 8
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic [1:0]        kind_i,
  input  logic [CAP_W-1:0]  cap_i,
  output logic              capturable_o
);
  import lcd_pkg::*;

  logic              eligible;
  logic              backward;
  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] body_words;
  logic              fits;

  always_comb begin
    eligible   = (kind_i == KIND_COND) || (kind_i == KIND_JUMP);
    backward   = target_i < pc_i;
    span       = pc_i - target_i;
    // span wraps when not backward; the result is masked by backward
    body_words = (span >> 2) + ADDR_W'(1);
    fits       = body_words <= ADDR_W'(cap_i);
    capturable_o = eligible && backward && fits;
  end
endmodule

// File: rtl/lcd_nbl_table.sv
module lcd_nbl_table #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] look_pc_i,
  output logic              hit_o,
  input  logic              ins_i,
  input  logic [ADDR_W-1:0] ins_tag_i
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic [DEPTH-1:0]  vld_q;
  logic [ADDR_W-1:0] tag_q [DEPTH];
  logic [IW-1:0]     ptr_q;
  logic [DEPTH-1:0]  match;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (tag_q[g] == look_pc_i);
  end

  assign hit_o = |match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) tag_q[i] <= '0;
    end else if (ins_i) begin
      vld_q[ptr_q] <= 1'b1;
      tag_q[ptr_q] <= ins_tag_i;
      ptr_q        <= (ptr_q == LAST) ? '0 : ptr_q + IW'(1);
    end
  end

  // entries are only ever filled, never dropped, outside reset
  assert_valid_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q & $past(vld_q)) == $past(vld_q));

  assert_ptr_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= LAST);

  assert_insert_visible_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_i |=> (tag_q[$past(ptr_q)] == $past(ins_tag_i)) && vld_q[$past(ptr_q)]);
endmodule

// File: rtl/loop_capture_detector.sv
module loop_capture_detector #(
  parameter int ADDR_W    = 32,
  parameter int CAP_W     = 8,
  parameter int NBL_DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dec_valid_i,
  input  logic [ADDR_W-1:0] dec_pc_i,
  input  logic [1:0]        dec_kind_i,
  input  logic [ADDR_W-1:0] dec_target_i,
  input  logic [CAP_W-1:0]  iq_cap_i,
  input  logic              ctl_normal_i,
  input  logic              abort_valid_i,
  input  logic [1:0]        abort_cause_i,
  input  logic [ADDR_W-1:0] abort_tag_i,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] req_start_pc_o,
  output logic [ADDR_W-1:0] req_end_pc_o
);
  import lcd_pkg::*;

  logic              capturable;
  logic              tbl_hit;
  logic              record;
  logic              bypass_hit;
  logic              fire;
  logic              req_v_q;
  logic [ADDR_W-1:0] start_q;
  logic [ADDR_W-1:0] end_q;

  lcd_qualify #(.ADDR_W(ADDR_W), .CAP_W(CAP_W)) u_qualify (
    .pc_i        (dec_pc_i),
    .target_i    (dec_target_i),
    .kind_i      (dec_kind_i),
    .cap_i       (iq_cap_i),
    .capturable_o(capturable)
  );

  assign record = abort_valid_i && cause_marks_bad(abort_cause_i);

  lcd_nbl_table #(.ADDR_W(ADDR_W), .DEPTH(NBL_DEPTH)) u_nbl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .look_pc_i(dec_pc_i),
    .hit_o    (tbl_hit),
    .ins_i    (record),
    .ins_tag_i(abort_tag_i)
  );

  // a tag being written this cycle already blocks the matching decode
  assign bypass_hit = record && (abort_tag_i == dec_pc_i);
  assign fire = dec_valid_i && ctl_normal_i && capturable && !tbl_hit && !bypass_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_v_q <= 1'b0;
      start_q <= '0;
      end_q   <= '0;
    end else begin
      req_v_q <= fire;
      if (fire) begin
        start_q <= dec_target_i;
        end_q   <= dec_pc_i;
      end
    end
  end

  assign req_valid_o    = req_v_q;
  assign req_start_pc_o = start_q;
  assign req_end_pc_o   = end_q;

  assert_kind_ok_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> ($past(dec_kind_i) == KIND_COND || $past(dec_kind_i) == KIND_JUMP));

  assert_backward_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> req_start_pc_o < req_end_pc_o);

  assert_fits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (((req_end_pc_o - req_start_pc_o) >> 2) + ADDR_W'(1)) <= ADDR_W'($past(iq_cap_i)));

  assert_req_fields_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> ($past(dec_valid_i) && req_end_pc_o == $past(dec_pc_i)
                     && req_start_pc_o == $past(dec_target_i)));

  assert_normal_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_normal_i |=> !req_valid_o);

  assert_bypass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && abort_valid_i && abort_cause_i != ABT_OTHER && abort_tag_i == dec_pc_i)
      |=> !req_valid_o);
endmodule

// File: tb/loop_capture_detector_tb.sv
module loop_capture_detector_tb;
  localparam int AW = 32;
  localparam int CW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          dec_valid_i = 1'b0;
  logic [AW-1:0] dec_pc_i = '0;
  logic [1:0]    dec_kind_i = 2'b00;
  logic [AW-1:0] dec_target_i = '0;
  logic [CW-1:0] iq_cap_i = 8'd32;
  logic          ctl_normal_i = 1'b1;
  logic          abort_valid_i = 1'b0;
  logic [1:0]    abort_cause_i = 2'b00;
  logic [AW-1:0] abort_tag_i = '0;
  logic          req_valid_o;
  logic [AW-1:0] req_start_pc_o;
  logic [AW-1:0] req_end_pc_o;

  loop_capture_detector u_dut (
    .clk_i, .rst_ni, .dec_valid_i, .dec_pc_i, .dec_kind_i, .dec_target_i,
    .iq_cap_i, .ctl_normal_i, .abort_valid_i, .abort_cause_i, .abort_tag_i,
    .req_valid_o, .req_start_pc_o, .req_end_pc_o
  );

  always #10 clk_i = ~clk_i;

  typedef struct {
    logic          v;
    logic [AW-1:0] s;
    logic [AW-1:0] e;
    string         rq;
    int            due;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // monitor: compare due item, otherwise expect silence
  always @(negedge clk_i) begin
    if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
      exp_t it;
      it = exp_q.pop_front();
      checks++;
      if (req_valid_o !== it.v ||
          (it.v && (req_start_pc_o !== it.s || req_end_pc_o !== it.e))) begin
        errors++;
        $display("FAIL %s: got v=%0b s=%h e=%h, expected v=%0b s=%h e=%h",
                 it.rq, req_valid_o, req_start_pc_o, req_end_pc_o, it.v, it.s, it.e);
      end
    end else if (rst_ni && req_valid_o !== 1'b0) begin
      checks++;
      errors++;
      $display("FAIL R4: unexpected request got v=%0b expected v=0", req_valid_o);
    end
  end

  task automatic idle();
    dec_valid_i   = 1'b0;
    abort_valid_i = 1'b0;
  endtask

  // drive one decode at a negedge; expectation is due one cycle later
  task automatic decode(input logic [AW-1:0] pc, input logic [AW-1:0] tgt,
                        input logic [1:0] kind, input logic vld,
                        input logic ev, input string rq);
    exp_t it;
    dec_valid_i  = vld;
    dec_pc_i     = pc;
    dec_target_i = tgt;
    dec_kind_i   = kind;
    it.v = ev; it.s = tgt; it.e = pc; it.rq = rq; it.due = cyc + 1;
    exp_q.push_back(it);
    @(negedge clk_i);
  endtask

  task automatic abort_rep(input logic [1:0] cause, input logic [AW-1:0] tag);
    abort_valid_i = 1'b1;
    abort_cause_i = cause;
    abort_tag_i   = tag;
    @(negedge clk_i);
    abort_valid_i = 1'b0;
  endtask

  task automatic do_reset();
    idle();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    checks++;
    if (req_valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R10: reset req got %0b expected 0", req_valid_o);
    end

    // R10/R1/R4: body 17 words, cap 32, conditional branch
    decode(32'h1040, 32'h1000, 2'b01, 1'b1, 1'b1, "R10 R1 R4 cond"); idle(); @(negedge clk_i);
    decode(32'h1040, 32'h1000, 2'b10, 1'b1, 1'b1, "R1 jump");         idle(); @(negedge clk_i);
    decode(32'h1040, 32'h1000, 2'b00, 1'b1, 1'b0, "R1 other");        idle(); @(negedge clk_i);
    decode(32'h1040, 32'h1000, 2'b11, 1'b1, 1'b0, "R1 call");         idle(); @(negedge clk_i);
    // R2
    decode(32'h1040, 32'h1080, 2'b01, 1'b1, 1'b0, "R2 forward");      idle(); @(negedge clk_i);
    decode(32'h1040, 32'h1040, 2'b01, 1'b1, 1'b0, "R2 equal");        idle(); @(negedge clk_i);
    // R3: size 17
    iq_cap_i = 8'd17;
    decode(32'h1040, 32'h1000, 2'b01, 1'b1, 1'b1, "R3 exact fit");    idle(); @(negedge clk_i);
    iq_cap_i = 8'd16;
    decode(32'h1040, 32'h1000, 2'b01, 1'b1, 1'b0, "R3 one over");     idle(); @(negedge clk_i);
    iq_cap_i = 8'd32;
    // R4: invalid decode, then back-to-back
    decode(32'h1040, 32'h1000, 2'b01, 1'b0, 1'b0, "R4 not valid");    idle(); @(negedge clk_i);
    decode(32'h3010, 32'h3000, 2'b01, 1'b1, 1'b1, "R4 b2b first");
    decode(32'h4020, 32'h4004, 2'b10, 1'b1, 1'b1, "R4 b2b second");   idle(); @(negedge clk_i);
    // R5
    ctl_normal_i = 1'b0;
    decode(32'h1040, 32'h1000, 2'b01, 1'b1, 1'b0, "R5 not normal");   idle(); @(negedge clk_i);
    ctl_normal_i = 1'b1;
    // R7: cause 00 does not record
    abort_rep(2'b00, 32'h1040);
    decode(32'h1040, 32'h1000, 2'b01, 1'b1, 1'b1, "R7 cause other");  idle(); @(negedge clk_i);
    // R6/R7: causes 01, 10, 11 record
    abort_rep(2'b01, 32'h1040);
    decode(32'h1040, 32'h1000, 2'b01, 1'b1, 1'b0, "R6 R7 inner");     idle(); @(negedge clk_i);
    abort_rep(2'b10, 32'h3010);
    decode(32'h3010, 32'h3000, 2'b01, 1'b1, 1'b0, "R7 exit");         idle(); @(negedge clk_i);
    abort_rep(2'b11, 32'h4020);
    decode(32'h4020, 32'h4004, 2'b10, 1'b1, 1'b0, "R7 call full");    idle(); @(negedge clk_i);
    // unrelated loop still passes
    decode(32'h5020, 32'h5000, 2'b01, 1'b1, 1'b1, "R6 other loop");   idle(); @(negedge clk_i);
    // R9: same-cycle record and decode
    abort_valid_i = 1'b1; abort_cause_i = 2'b01; abort_tag_i = 32'h6020;
    decode(32'h6020, 32'h6000, 2'b01, 1'b1, 1'b0, "R9 bypass");       idle(); @(negedge clk_i);

    // R8: round-robin eviction after reset
    do_reset();
    decode(32'h1040, 32'h1000, 2'b01, 1'b1, 1'b1, "R10 table empty"); idle(); @(negedge clk_i);
    for (int i = 0; i < 9; i++) abort_rep(2'b01, 32'h8000 + 32'(i) * 32'h100 + 32'h40);
    decode(32'h8040, 32'h8000, 2'b01, 1'b1, 1'b1, "R8 first evicted");  idle(); @(negedge clk_i);
    decode(32'h8140, 32'h8100, 2'b01, 1'b1, 1'b0, "R8 second kept");    idle(); @(negedge clk_i);
    decode(32'h8840, 32'h8800, 2'b01, 1'b1, 1'b0, "R8 newest kept");    idle(); @(negedge clk_i);

    repeat (3) @(negedge clk_i);
    if (exp_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R4: %0d pending got unchecked expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule